// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block keeps a 16-entry character store and shows it on a multiplexed display. Its own scan counter steps through the digits at a fixed rate. While the counter points at digit d, the two 4-bit output ports carry entry d. Port A carries bits 7:4 and port B carries bits 3:0. Together the two ports act as one 8-bit port when the store is written a byte at a time. A mode input selects an 8-digit or a 16-digit display. A blanking output covers each digit change, so the segment drivers can be turned off while the scan lines and data settle.

The host writes characters through an internal write pointer. In left entry, each write lands at the pointer, and the pointer then steps forward, wrapping at the selected digit count. The host can load the pointer directly. In right entry, each write moves the visible characters one place toward digit 0 and puts the new character in the last active digit. In dual-nibble organisation a write may update only the port A half or only the port B half of an entry. In byte organisation every write updates the whole entry.

Top module: `seg_refresh_top`

## Requirements
- R1: During and after reset, every entry of the store holds BLANK_CODE, scanIdx is 0, blank is 1 and the write pointer is 0.
- R2: scanIdx advances by one every SCAN_DIV clocks. From the last active digit it returns to 0. The last active digit is 7 when fullDigits=0 and 15 when fullDigits=1.
- R3: While scanIdx=d, outA equals bits 7:4 of entry d and outB equals bits 3:0 of entry d. Without a write strobe the store does not change.
- R4: blank is 1 during the BLANK_CLKS clocks before each scanIdx change and during the BLANK_CLKS clocks starting with the change. It is 0 at all other times.
- R5: In left entry (rightEntry=0), a write (wrEn=1) stores at the pointer. The pointer then increments and wraps to 0 after the last active digit (7 or 15).
- R6: addrLoad=1 sets the pointer to addrValue, using only addrValue[2:0] when fullDigits=0. A write in the same cycle is dropped.
- R7: In right entry, a write moves entry i+1 into entry i for every active digit below the last, and stores wrData in the last active digit. Entries above the active range and the pointer are unchanged.
- R8: In left entry with byteMode=0, nibEn[1] enables the write of bits 7:4 and nibEn[0] enables the write of bits 3:0. With byteMode=1, the whole byte is written whatever the value of nibEn.
- R9: In right entry the whole byte is written whatever the values of nibEn and byteMode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write one character |
| wrData | input | 8 | Character to write |
| addrLoad | input | 1 | Load the write pointer; takes priority over wrEn |
| addrValue | input | 4 | Value loaded into the write pointer |
| nibEn | input | 2 | Nibble write enables in dual-nibble mode (bit1 = port A half, bit0 = port B half) |
| fullDigits | input | 1 | 1 = 16 digits, 0 = 8 digits |
| rightEntry | input | 1 | 1 = right (shifting) entry, 0 = left entry |
| byteMode | input | 1 | 1 = single 8-bit organisation, 0 = dual 4-bit |
| scanIdx | output | 4 | Encoded scan count (current digit) |
| outA | output | 4 | Port A: upper nibble of the current digit |
| outB | output | 4 | Port B: lower nibble of the current digit |
| blank | output | 1 | Display blanking around each digit change |

## Verification
The hardest case to reach is a right-entry shift in 8-digit mode. The shift must leave entries 8 to 15 alone, and those entries cannot be seen until the display is switched to 16 digits. The stimulus fills all 16 entries, switches to 8 digits, shifts in right-entry mode, and then switches back to 16 digits so a full frame shows the untouched upper half. A pointer load in the same cycle as a write, and nibble writes that clear both enables, are both followed by a full frame compare. Any stray change to the store is therefore seen at the ports.

// File: rtl/seg_refresh_pkg.sv
package seg_refresh_pkg;
  localparam int MAX_DIGITS = 16;
  localparam int IDX_W      = $clog2(MAX_DIGITS);
  localparam int CHAR_W     = 8;
  localparam int NIB_W      = CHAR_W / 2;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrLeft;
    logic             wrShift;
    logic [IDX_W-1:0] wrAddr;
    logic [1:0]       nibEn;
    logic             fullDigits;
  } dpStrobe_t;
endpackage

// File: rtl/seg_refresh_ctrl.sv
module seg_refresh_ctrl
  import seg_refresh_pkg::*;
#(
  parameter int SCAN_DIV   = 32,
  parameter int BLANK_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             addrLoad,
  input  logic [IDX_W-1:0] addrValue,
  input  logic [1:0]       nibEn,
  input  logic             fullDigits,
  input  logic             rightEntry,
  input  logic             byteMode,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] scanIdx,
  output logic             blank
);
  localparam int DIV_W = $clog2(SCAN_DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCAN_DIV - 1);
  localparam logic [DIV_W-1:0] BLK_LO   = DIV_W'(BLANK_CLKS);
  localparam logic [DIV_W-1:0] BLK_HI   = DIV_W'(SCAN_DIV - BLANK_CLKS);

  initial assert (SCAN_DIV > 2 * BLANK_CLKS && SCAN_DIV >= 2);

  logic [DIV_W-1:0] divCnt, divNext;
  logic [IDX_W-1:0] lastIdx, wrAddr;
  logic             blankQ;

  assign lastIdx = fullDigits ? IDX_W'(MAX_DIGITS - 1) : IDX_W'(MAX_DIGITS / 2 - 1);
  assign divNext = (divCnt == DIV_LAST) ? '0 : divCnt + 1'b1;

  // scan timing and blanking window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divCnt  <= '0;
      scanIdx <= '0;
      blankQ  <= 1'b1;
    end else begin
      divCnt <= divNext;
      blankQ <= (divNext < BLK_LO) || (divNext >= BLK_HI);
      if (divCnt == DIV_LAST)
        scanIdx <= (scanIdx >= lastIdx) ? '0 : scanIdx + 1'b1;
    end
  end
  assign blank = blankQ;

  // write pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrAddr <= '0;
    end else if (addrLoad) begin
      wrAddr <= fullDigits ? addrValue : {1'b0, addrValue[IDX_W-2:0]};
    end else if (wrEn && !rightEntry) begin
      wrAddr <= (wrAddr >= lastIdx) ? '0 : wrAddr + 1'b1;
    end
  end

  always_comb begin
    strobe.wrLeft     = wrEn && !addrLoad && !rightEntry;
    strobe.wrShift    = wrEn && !addrLoad && rightEntry;
    strobe.wrAddr     = wrAddr;
    strobe.nibEn      = byteMode ? 2'b11 : nibEn;
    strobe.fullDigits = fullDigits;
  end

  p_scan_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scanIdx) |-> (scanIdx == $past(scanIdx) + 1'b1) || (scanIdx == '0));
  p_blank_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scanIdx) |-> blankQ && $past(blankQ));
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !addrLoad && !rightEntry) |=> (wrAddr == $past(wrAddr) + 1'b1) || (wrAddr == '0));
  p_ptr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addrLoad && fullDigits) |=> wrAddr == $past(addrValue));
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && rightEntry && !addrLoad) |=> $stable(wrAddr));
endmodule

// File: rtl/seg_refresh_dp.sv
module seg_refresh_dp
  import seg_refresh_pkg::*;
#(
  parameter logic [CHAR_W-1:0] BLANK_CODE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [CHAR_W-1:0] wrData,
  input  logic [IDX_W-1:0]  scanIdx,
  output logic [NIB_W-1:0]  outA,
  output logic [NIB_W-1:0]  outB
);
  logic [MAX_DIGITS-1:0][CHAR_W-1:0] mem;
  logic [IDX_W-1:0] lastIdx;
  logic [CHAR_W-1:0] curChar;

  assign lastIdx = strobe.fullDigits ? IDX_W'(MAX_DIGITS - 1) : IDX_W'(MAX_DIGITS / 2 - 1);

  for (genvar g = 0; g < MAX_DIGITS; g++) begin : g_cell
    localparam logic [IDX_W-1:0] POS = IDX_W'(g);
    localparam int NB = (g + 1) % MAX_DIGITS;
    logic [CHAR_W-1:0] cellQ, cellNext;

    always_comb begin
      cellNext = cellQ;
      if (strobe.wrShift) begin
        if (POS < lastIdx)       cellNext = mem[NB];
        else if (POS == lastIdx) cellNext = wrData;
      end else if (strobe.wrLeft && strobe.wrAddr == POS) begin
        if (strobe.nibEn[1]) cellNext[CHAR_W-1:NIB_W] = wrData[CHAR_W-1:NIB_W];
        if (strobe.nibEn[0]) cellNext[NIB_W-1:0]      = wrData[NIB_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cellQ <= BLANK_CODE;
      else        cellQ <= cellNext;
    end
    assign mem[g] = cellQ;
  end

  assign curChar = mem[scanIdx];
  assign outA    = curChar[CHAR_W-1:NIB_W];
  assign outB    = curChar[NIB_W-1:0];

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.wrLeft || strobe.wrShift) |=> $stable(mem));
  p_shift_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrShift && strobe.fullDigits) |=>
      mem[MAX_DIGITS-1] == $past(wrData) && mem[MAX_DIGITS-2] == $past(mem[MAX_DIGITS-1]));
  p_shift_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrShift && !strobe.fullDigits) |=>
      $stable(mem[MAX_DIGITS-1:MAX_DIGITS/2]) && mem[MAX_DIGITS/2-1] == $past(wrData));
  p_nib_low_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrLeft && strobe.nibEn == 2'b01) |=>
      mem[$past(strobe.wrAddr)][CHAR_W-1:NIB_W] == $past(mem[strobe.wrAddr][CHAR_W-1:NIB_W]));
endmodule

// File: rtl/seg_refresh_top.sv
module seg_refresh_top
  import seg_refresh_pkg::*;
#(
  parameter int                SCAN_DIV   = 32,
  parameter int                BLANK_CLKS = 2,
  parameter logic [CHAR_W-1:0] BLANK_CODE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [CHAR_W-1:0] wrData,
  input  logic              addrLoad,
  input  logic [IDX_W-1:0]  addrValue,
  input  logic [1:0]        nibEn,
  input  logic              fullDigits,
  input  logic              rightEntry,
  input  logic              byteMode,
  output logic [IDX_W-1:0]  scanIdx,
  output logic [NIB_W-1:0]  outA,
  output logic [NIB_W-1:0]  outB,
  output logic              blank
);
  dpStrobe_t strobe;

  seg_refresh_ctrl #(.SCAN_DIV(SCAN_DIV), .BLANK_CLKS(BLANK_CLKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addrLoad(addrLoad),
    .addrValue(addrValue), .nibEn(nibEn), .fullDigits(fullDigits),
    .rightEntry(rightEntry), .byteMode(byteMode), .strobe(strobe),
    .scanIdx(scanIdx), .blank(blank)
  );

  seg_refresh_dp #(.BLANK_CODE(BLANK_CODE)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .scanIdx(scanIdx), .outA(outA), .outB(outB)
  );
endmodule

// File: tb/sim_seg_refresh_top.sv
`timescale 1ns/1ps
module sim_seg_refresh_top;
  localparam int DIV = 16;
  localparam int BLK = 2;
  localparam logic [7:0] CODE = 8'h3C;

  logic clk = 0, rst_n = 0;
  logic wrEn = 0, addrLoad = 0, fullDigits = 1, rightEntry = 0, byteMode = 1;
  logic [7:0] wrData = 0;
  logic [3:0] addrValue = 0;
  logic [1:0] nibEn = 2'b11;
  logic [3:0] scanIdx, outA, outB;
  logic blank;

  always #10 clk = ~clk;

  seg_refresh_top #(.SCAN_DIV(DIV), .BLANK_CLKS(BLK), .BLANK_CODE(CODE)) u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .addrLoad(addrLoad),
    .addrValue(addrValue), .nibEn(nibEn), .fullDigits(fullDigits),
    .rightEntry(rightEntry), .byteMode(byteMode), .scanIdx(scanIdx),
    .outA(outA), .outB(outB), .blank(blank));

  int nTests = 0, nFail = 0;
  bit finished = 0;

  typedef struct { int dig; logic [7:0] val; string tag; } item_t;
  item_t q[$];
  logic [7:0] model [16];
  int mAddr = 0;

  function automatic int activeCnt();
    return fullDigits ? 16 : 8;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one write, model updated from the requirements
  task automatic wr(input logic [7:0] d, input logic [1:0] ne);
    int n;
    n = activeCnt();
    @(negedge clk); wrData = d; nibEn = ne; wrEn = 1;
    @(negedge clk); wrEn = 0;
    if (rightEntry) begin
      for (int i = 0; i < n - 1; i++) model[i] = model[i+1];
      model[n-1] = d;
    end else begin
      if (byteMode || ne[1]) model[mAddr][7:4] = d[7:4];
      if (byteMode || ne[0]) model[mAddr][3:0] = d[3:0];
      mAddr = (mAddr + 1) % n;
    end
  endtask

  task automatic ld(input logic [3:0] v, input bit withWrite);
    @(negedge clk); addrValue = v; addrLoad = 1; wrEn = withWrite; wrData = 8'hEE;
    @(negedge clk); addrLoad = 0; wrEn = 0;
    mAddr = fullDigits ? int'(v) : int'(v[2:0]);
  endtask

  task automatic expectFrame(input string tag);
    item_t it;
    for (int d = 0; d < activeCnt(); d++) begin
      it.dig = d; it.val = model[d]; it.tag = tag;
      q.push_back(it);
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor: pops expected characters as their digit is shown
  initial forever begin
    @(negedge clk);
    if (rst_n && q.size() > 0 && !blank && int'(scanIdx) == q[0].dig) begin
      item_t it;
      it = q.pop_front();
      chk({outA, outB} == it.val, $sformatf("%s digit %0d", it.tag, it.dig),
          {outA, outB}, it.val);
    end
  end

  // scan and blank monitor (R2, R4)
  int cyc = -1, lastIdx = 0, blankErr = 0;
  bit seen = 0;
  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      cyc = -1; lastIdx = 0; blankErr = 0; seen = 0;
    end else begin
      if (int'(scanIdx) != lastIdx) begin
        bit stepOk;
        stepOk = (int'(scanIdx) == lastIdx + 1) || (scanIdx == 0 && lastIdx >= activeCnt() - 1);
        chk(stepOk, "R2 scan step", scanIdx, (lastIdx + 1) % activeCnt());
        if (seen) chk(cyc + 1 == DIV, "R2 digit period", cyc + 1, DIV);
        chk(blankErr == 0, "R4 blank window", blankErr, 0);
        blankErr = 0; cyc = 0; seen = 1; lastIdx = scanIdx;
      end else begin
        cyc++;
      end
      if (blank != ((cyc < BLK) || (cyc >= DIV - BLK))) blankErr++;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = CODE;
    repeat (3) @(posedge clk);
    #1;
    chk(scanIdx == 0, "R1 reset scanIdx", scanIdx, 0);
    chk(blank == 1'b1, "R1 reset blank", blank, 1);
    chk({outA, outB} == CODE, "R1 reset output", {outA, outB}, CODE);
    @(posedge clk); #2 rst_n = 1;
    expectFrame("R1 blank fill");

    // left entry, 16 digits, byte mode: R3, R5
    for (int i = 0; i < 16; i++) wr(8'h10 + 8'(i), 2'b00);
    expectFrame("R3 R5 fill 16");
    wr(8'hA0, 2'b11); wr(8'hA1, 2'b11);
    expectFrame("R5 wrap at 16");

    // 8 digits: wrap at 8
    fullDigits = 0;
    ld(4'd0, 0);
    for (int i = 0; i < 9; i++) wr(8'h50 + 8'(i), 2'b11);
    expectFrame("R5 wrap at 8");

    // pointer load, masked, and write dropped
    ld(4'd13, 0);
    wr(8'h77, 2'b11);
    ld(4'd2, 1);
    wr(8'h78, 2'b11);
    expectFrame("R6 load");

    // dual nibble writes
    byteMode = 0;
    ld(4'd0, 0);
    wr(8'hC9, 2'b10); wr(8'hD4, 2'b01); wr(8'hFF, 2'b00);
    expectFrame("R8 nibble");
    byteMode = 1;
    wr(8'h6B, 2'b00);
    expectFrame("R8 byte ignores nibEn");

    // right entry in 8 digits, nibEn ignored
    rightEntry = 1; byteMode = 0;
    wr(8'h81, 2'b01); wr(8'h82, 2'b00); wr(8'h83, 2'b10);
    expectFrame("R7 R9 shift 8");
    fullDigits = 1;
    expectFrame("R7 upper untouched");
    wr(8'h91, 2'b00); wr(8'h92, 2'b00);
    expectFrame("R7 R9 shift 16");

    // pointer unchanged by right entry
    rightEntry = 0; byteMode = 1;
    wr(8'hB7, 2'b11);
    expectFrame("R7 pointer held");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule